// File: doc/BRIEF.md
# Converter Read Sequencer

This block is a bus master for a successive-approximation converter with a parallel output. It drives the converter's chip-select, read strobe and byte-select lines. Each conversion result comes back as a right-justified 16-bit word on a valid/ready output. The same read that fetches data also starts the next conversion, so the sequencer also decides when conversions happen. All timing limits are counted in host clock cycles.

There are two timing strategies. In wait mode, the strobe of the read that starts a conversion is held low until the converter's idle line has gone low and then high again. The fresh result is then taken from the same strobe. In no-wait mode, each read returns the result of the previous conversion and starts a new one. The first read after reset only primes the pipe, and its data is dropped. Either strategy can use a 12-bit path or an 8-bit path. On the 8-bit path, a second read with byte-select high fetches the top four result bits on data lines 3..0. Byte-select high never starts a conversion.

A watchdog counts how long a wait-mode strobe has been low. It abandons the read if the converter never finishes.

Top module: `adc_rdseq`

## Requirements
- R1: While reset is asserted, chip-select and read are high (inactive), byte-select is low, and both the sample valid and the error output are low.
- R2: The read strobe falls only after chip-select has been low for at least one cycle. Chip-select is still low in the cycle the strobe rises. Byte-select holds one value for as long as chip-select is low.
- R3: Byte-select is driven high only on the 8-bit path, and only for the high-part read. Two consecutive reads never both have byte-select high. A read with byte-select low starts a conversion.
- R4: Wait mode, 12-bit path. Each sample uses one read with byte-select low. The read is held until the idle input has been seen low and then high. The word delivered is {4'b0, adc_d[11:0]} sampled at that point.
- R5: Wait mode, 8-bit path. The first read (byte-select low) completes as in R4 and captures adc_d[7:0]. A second read with byte-select high captures adc_d[3:0] as result bits 11..8. Lines 7..4 are ignored.
- R6: No-wait mode, 12-bit path. After reset, the first read is discarded. Every later read returns the result of the conversion started by the read before it.
- R7: No-wait mode, 8-bit path. After the discarded priming read, each sample is fetched in two reads. First comes a byte-select-high read giving bits 11..8 on adc_d[3:0]. Then comes a byte-select-low read giving bits 7..0, which also starts the next conversion.
- R8: Reads that start a conversion fall at least CONV_CYC+ACQ_CYC cycles apart. A high-part read in no-wait mode falls at least CONV_CYC cycles after the last conversion start.
- R9: Between any two reads, chip-select stays high for at least RD_GAP cycles.
- R10: Once smp_valid rises, it stays high with smp_data unchanged until a cycle with smp_ready high. No conversion-starting read begins while smp_valid is high.
- R11: If, in wait mode, the idle input does not complete its low-then-high cycle within 2*CONV_CYC cycles of the strobe falling, three things happen. tmo_err pulses for exactly one cycle, in the cycle the strobe rises, 2*CONV_CYC cycles after it fell. No sample is delivered. The sequence restarts with a byte-select-low read.
- R12: Bits 15..12 of every delivered word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nowait | input | 1 | 1 = no-wait strategy, 0 = wait strategy; taken at sample boundaries |
| cfg_byte | input | 1 | 1 = 8-bit two-read path, 0 = 12-bit path; taken at sample boundaries |
| cs_n | output | 1 | Converter chip-select, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| hbyte_sel | output | 1 | Byte-select: 1 selects the high part and suppresses conversion start |
| adc_d | input | ADC_W | Converter data lines |
| adc_idle | input | 1 | High when the converter is not converting |
| smp_data | output | OUT_W | Right-justified sample |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts the sample |
| tmo_err | output | 1 | One-cycle pulse on a wait-mode timeout |

## Verification
The bench builds the block with CONV_CYC=20, ACQ_CYC=5, RD_PULSE=2 and RD_GAP=2. These small values mean each of the four mode combinations delivers ten samples within a few hundred cycles. They also make the 40-cycle timeout window short enough to reach on purpose, by having the converter model ignore a start. The model's conversion times are random between CONV_CYC/2 and CONV_CYC, so in wait mode the busy edge arrives at many different strobe ages. The consumer's ready line is random, with a directed stretch held low, so spacing checks and the ban on starting a conversion while a sample is pending are hit repeatedly.

// File: rtl/adc_rdseq_pkg.sv
package adc_rdseq_pkg;

    // Phases of one read operation on the converter bus.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STRB,
        SQ_HOLD,
        SQ_GAP
    } sq_state_e;

endpackage

// File: rtl/adc_rdseq_since.sv
// Counts cycles since the last conversion-starting strobe and reports
// when the conversion is surely over and when a new start is allowed.
module adc_rdseq_since #(
    parameter int unsigned CONV_CYC = 135,
    parameter int unsigned ACQ_CYC  = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic conv_over_o,
    output logic start_ok_o
);
    localparam int unsigned LIMIT = CONV_CYC + ACQ_CYC;
    localparam int unsigned TW    = $clog2(LIMIT + 1) + 1;
    localparam logic [TW-1:0] LIM_V  = TW'(LIMIT);
    localparam logic [TW-1:0] CONV_V = TW'(CONV_CYC);

    logic [TW-1:0] since_d, since_q;

    always_comb begin
        since_d = since_q;
        if (start_i) begin
            since_d = '0;
        end else if (since_q < LIM_V) begin
            since_d = since_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= LIM_V;
        end else begin
            since_q <= since_d;
        end
    end

    assign conv_over_o = (since_q >= CONV_V);
    assign start_ok_o  = (since_q >= LIM_V);

    // R8
    start_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> start_ok_o);

endmodule

// File: rtl/adc_rdseq_pack.sv
// Builds the right-justified output word from either the full bus or
// the two captured parts.
module adc_rdseq_pack #(
    parameter int unsigned ADC_W = 12,
    parameter int unsigned LO_W  = 8,
    parameter int unsigned OUT_W = 16,
    localparam int unsigned HI_W = ADC_W - LO_W
) (
    input  logic             byte_path_i,
    input  logic [ADC_W-1:0] full_i,
    input  logic [LO_W-1:0]  lo_i,
    input  logic [HI_W-1:0]  hi_i,
    output logic [OUT_W-1:0] word_o
);
    logic [ADC_W-1:0] merged;

    assign merged = byte_path_i ? {hi_i, lo_i} : full_i;

    generate
        if (OUT_W > ADC_W) begin : g_pad
            assign word_o = {{(OUT_W - ADC_W){1'b0}}, merged};
        end else begin : g_nopad
            assign word_o = merged[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/adc_rdseq_outbuf.sv
// Single output register with a valid/ready handshake.
module adc_rdseq_outbuf #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         ready_i,
    output logic         valid_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } ob_t;

    ob_t ob_d, ob_q;

    always_comb begin
        ob_d = ob_q;
        if (ob_q.valid && ready_i) begin
            ob_d.valid = 1'b0;
        end
        if (load_i) begin
            ob_d.valid = 1'b1;
            ob_d.data  = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ob_q <= '0;
        end else begin
            ob_q <= ob_d;
        end
    end

    assign valid_o = ob_q.valid;
    assign data_o  = ob_q.data;

    // R10
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

    // R10
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !valid_o);

endmodule

// File: rtl/adc_rdseq.sv
module adc_rdseq
    import adc_rdseq_pkg::*;
#(
    parameter int unsigned ADC_W    = 12,
    parameter int unsigned OUT_W    = 16,
    parameter int unsigned LO_W     = 8,
    parameter int unsigned CONV_CYC = 135,
    parameter int unsigned ACQ_CYC  = 30,
    parameter int unsigned RD_PULSE = 3,
    parameter int unsigned RD_GAP   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_nowait,
    input  logic             cfg_byte,
    output logic             cs_n,
    output logic             rd_n,
    output logic             hbyte_sel,
    input  logic [ADC_W-1:0] adc_d,
    input  logic             adc_idle,
    output logic [OUT_W-1:0] smp_data,
    output logic             smp_valid,
    input  logic             smp_ready,
    output logic             tmo_err
);
    localparam int unsigned HI_W    = ADC_W - LO_W;
    localparam int unsigned TMO_CYC = 2 * CONV_CYC;
    localparam int unsigned PMAX    = (RD_PULSE > RD_GAP) ? RD_PULSE : RD_GAP;
    localparam int unsigned PW      = $clog2(PMAX + 1) + 1;
    localparam int unsigned MW      = $clog2(TMO_CYC + 1) + 1;
    localparam logic [PW-1:0] PULSE_LAST = PW'(RD_PULSE - 1);
    localparam logic [PW-1:0] GAP_LAST   = PW'(RD_GAP - 1);
    localparam logic [MW-1:0] TMO_LAST   = MW'(TMO_CYC - 1);

    typedef struct packed {
        sq_state_e       st;
        logic            hb;        // byte-select of current read
        logic            starts;    // current read starts a conversion
        logic            waits;     // strobe held until converter finishes
        logic            finish;    // current read completes a sample
        logic            discard;   // priming read, data dropped
        logic            step;      // position inside a two-read sample
        logic            primed;
        logic            seen_low;
        logic            err;
        logic            nw;
        logic            bp;
        logic [PW-1:0]   cnt;
        logic [MW-1:0]   tmo;
        logic [LO_W-1:0] lo;
        logic [HI_W-1:0] hi;
    } seq_t;

    seq_t seq_d, seq_q;

    logic             start_pulse;
    logic             load;
    logic             conv_over;
    logic             start_ok;
    logic             eff_nw, eff_bp, eff_primed, go;
    logic [OUT_W-1:0] word;
    logic [LO_W-1:0]  lo_mux;
    logic [HI_W-1:0]  hi_mux;

    adc_rdseq_since #(
        .CONV_CYC (CONV_CYC),
        .ACQ_CYC  (ACQ_CYC)
    ) u_since (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_pulse),
        .conv_over_o (conv_over),
        .start_ok_o  (start_ok)
    );

    assign lo_mux = seq_q.hb ? seq_q.lo : adc_d[LO_W-1:0];
    assign hi_mux = seq_q.hb ? adc_d[HI_W-1:0] : seq_q.hi;

    adc_rdseq_pack #(
        .ADC_W (ADC_W),
        .LO_W  (LO_W),
        .OUT_W (OUT_W)
    ) u_pack (
        .byte_path_i (seq_q.bp),
        .full_i      (adc_d),
        .lo_i        (lo_mux),
        .hi_i        (hi_mux),
        .word_o      (word)
    );

    adc_rdseq_outbuf #(
        .W (OUT_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .data_i  (word),
        .ready_i (smp_ready),
        .valid_o (smp_valid),
        .data_o  (smp_data)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.err   = 1'b0;
        load        = 1'b0;
        start_pulse = 1'b0;
        go          = 1'b0;
        // Configuration is only taken at a sample boundary.
        eff_nw     = seq_q.step ? seq_q.nw : cfg_nowait;
        eff_bp     = seq_q.step ? seq_q.bp : cfg_byte;
        eff_primed = seq_q.primed &&
                     !(!seq_q.step && ((cfg_nowait != seq_q.nw) || (cfg_byte != seq_q.bp)));

        unique case (seq_q.st)
            SQ_IDLE: begin
                seq_d.nw     = eff_nw;
                seq_d.bp     = eff_bp;
                seq_d.primed = eff_primed;
                if (!eff_nw) begin
                    if (!seq_q.step) begin
                        if (!smp_valid && start_ok) begin
                            go = 1'b1; seq_d.hb = 1'b0; seq_d.starts = 1'b1;
                            seq_d.waits = 1'b1; seq_d.discard = 1'b0; seq_d.finish = !eff_bp;
                        end
                    end else begin
                        go = 1'b1; seq_d.hb = 1'b1; seq_d.starts = 1'b0;
                        seq_d.waits = 1'b0; seq_d.discard = 1'b0; seq_d.finish = 1'b1;
                    end
                end else if (!eff_primed) begin
                    if (!smp_valid && start_ok) begin
                        go = 1'b1; seq_d.hb = 1'b0; seq_d.starts = 1'b1;
                        seq_d.waits = 1'b0; seq_d.discard = 1'b1; seq_d.finish = 1'b0;
                    end
                end else if (!eff_bp || seq_q.step) begin
                    if (!smp_valid && start_ok) begin
                        go = 1'b1; seq_d.hb = 1'b0; seq_d.starts = 1'b1;
                        seq_d.waits = 1'b0; seq_d.discard = 1'b0; seq_d.finish = 1'b1;
                    end
                end else begin
                    if (conv_over) begin
                        go = 1'b1; seq_d.hb = 1'b1; seq_d.starts = 1'b0;
                        seq_d.waits = 1'b0; seq_d.discard = 1'b0; seq_d.finish = 1'b0;
                    end
                end
                if (go) begin
                    seq_d.st = SQ_SETUP;
                end
            end
            SQ_SETUP: begin
                seq_d.st       = SQ_STRB;
                seq_d.cnt      = '0;
                seq_d.tmo      = '0;
                seq_d.seen_low = 1'b0;
                start_pulse    = seq_q.starts;
            end
            SQ_STRB: begin
                if (seq_q.cnt < PULSE_LAST) begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
                if (seq_q.tmo != '1) begin
                    seq_d.tmo = seq_q.tmo + 1'b1;
                end
                if (!adc_idle) begin
                    seq_d.seen_low = 1'b1;
                end
                if (seq_q.waits && (seq_q.tmo >= TMO_LAST)) begin
                    seq_d.err  = 1'b1;
                    seq_d.step = 1'b0;
                    seq_d.st   = SQ_HOLD;
                end else if ((seq_q.cnt >= PULSE_LAST) &&
                             (!seq_q.waits || (seq_q.seen_low && adc_idle))) begin
                    seq_d.st = SQ_HOLD;
                    if (seq_q.discard) begin
                        seq_d.primed = 1'b1;
                    end else begin
                        if (seq_q.hb) begin
                            seq_d.hi = adc_d[HI_W-1:0];
                        end else begin
                            seq_d.lo = adc_d[LO_W-1:0];
                        end
                        if (seq_q.finish) begin
                            load       = 1'b1;
                            seq_d.step = 1'b0;
                        end else begin
                            seq_d.step = 1'b1;
                        end
                    end
                end
            end
            SQ_HOLD: begin
                seq_d.st  = SQ_GAP;
                seq_d.cnt = '0;
            end
            SQ_GAP: begin
                if (seq_q.cnt >= GAP_LAST) begin
                    seq_d.st = SQ_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= SQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n      = !((seq_q.st == SQ_SETUP) || (seq_q.st == SQ_STRB) || (seq_q.st == SQ_HOLD));
    assign rd_n      = (seq_q.st != SQ_STRB);
    assign hbyte_sel = seq_q.hb;
    assign tmo_err   = seq_q.err;

    // R2
    cs_leads_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> !$past(cs_n));

    // R2
    cs_trails_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> !cs_n);

    // R2
    hb_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> $stable(hbyte_sel));

    // R10
    no_start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) && !hbyte_sel) |-> !smp_valid);

    // R11
    tmo_ends_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> (rd_n && !$past(rd_n)));

endmodule

// File: tb/adc_rdseq_tb_top.sv
module adc_rdseq_tb_top;
    localparam int CONV  = 20;
    localparam int ACQ   = 5;
    localparam int PULSE = 2;
    localparam int GAP   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nowait = 1'b0;
    logic        cfg_byte = 1'b0;
    logic        adc_idle = 1'b1;
    logic        smp_ready = 1'b0;
    logic [11:0] adc_d;
    logic        cs_n, rd_n, hbs, smp_valid, tmo_err;
    logic [15:0] smp_data;

    always #10 clk = ~clk;

    adc_rdseq #(
        .ADC_W (12), .OUT_W (16), .LO_W (8),
        .CONV_CYC (CONV), .ACQ_CYC (ACQ), .RD_PULSE (PULSE), .RD_GAP (GAP)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_nowait (cfg_nowait), .cfg_byte (cfg_byte),
        .cs_n (cs_n), .rd_n (rd_n), .hbyte_sel (hbs), .adc_d (adc_d),
        .adc_idle (adc_idle), .smp_data (smp_data), .smp_valid (smp_valid),
        .smp_ready (smp_ready), .tmo_err (tmo_err)
    );

    // Converter model: output latch, with byte-select folding the top part down.
    logic [11:0] latch = 12'h5A3;
    logic [11:0] pending = 12'h000;
    assign adc_d = hbs ? {latch[11:8], 4'h0, latch[11:8]} : latch;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rem = 0, delivered = 0, err_cnt = 0;
    int last_start = -1, last_fall = 0, cs_run = 1000;
    bit conv = 0, ignore = 0, stall = 0, finished = 0;
    bit prev_cs = 1, prev_rd = 1, prev_hb = 0, prev_err = 0, prev_vh = 0, last_hb_rd = 0;
    logic [15:0] prev_data = '0;
    logic [11:0] expq[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] expect_word(input logic [11:0] r);
        return {4'h0, r};
    endfunction

    always @(negedge clk) begin
        logic [11:0] e;
        cyc++;
        if (!rst_n) begin
            conv = 0; adc_idle = 1'b1; expq.delete(); last_start = -1; cs_run = 1000;
            prev_cs = 1; prev_rd = 1; prev_hb = 0; prev_err = 0; prev_vh = 0; last_hb_rd = 0;
            delivered = 0; err_cnt = 0; smp_ready = 1'b0;
        end else begin
            if (prev_rd && !rd_n) begin
                chk(!prev_cs, "R2", prev_cs, 0);
                chk(hbs == prev_hb, "R2", hbs, prev_hb);
                last_fall = cyc;
                if (!hbs) begin
                    chk(!smp_valid, "R10", smp_valid, 0);
                    if (last_start >= 0)
                        chk(cyc - last_start >= CONV + ACQ, "R8", cyc - last_start, CONV + ACQ);
                    last_start = cyc;
                    if (!conv && !ignore) begin
                        conv = 1;
                        rem = CONV / 2 + int'($urandom % (CONV / 2 + 1));
                        pending = 12'($urandom);
                        adc_idle = 1'b0;
                    end
                end else begin
                    chk(cfg_byte, "R3", cfg_byte, 1);
                    chk(!last_hb_rd, "R3", last_hb_rd, 0);
                    if (cfg_nowait)
                        chk(cyc - last_start >= CONV, "R8", cyc - last_start, CONV);
                end
                last_hb_rd = hbs;
            end else if (conv) begin
                rem--;
                if (rem <= 0) begin
                    conv = 0; latch = pending; adc_idle = 1'b1;
                    expq.push_back(pending);
                end
            end
            if (prev_cs && !cs_n) chk(cs_run >= GAP, "R9", cs_run, GAP);
            if (cs_n) cs_run++; else cs_run = 0;
            if (tmo_err) begin
                chk(!prev_err, "R11", prev_err, 0);
                chk(cyc - last_fall == 2 * CONV, "R11", cyc - last_fall, 2 * CONV);
                err_cnt++;
            end
            if (prev_vh) begin
                chk(smp_valid, "R10", smp_valid, 1);
                chk(smp_data == prev_data, "R10", smp_data, prev_data);
            end
            smp_ready = stall ? 1'b0 : (($urandom % 3) != 0);
            if (smp_valid && smp_ready) begin
                chk(smp_data[15:12] == 4'h0, "R12", smp_data[15:12], 0);
                e = (expq.size() > 0) ? expq.pop_front() : 12'hFFF;
                case ({cfg_nowait, cfg_byte})
                    2'b00:   chk(smp_data == expect_word(e), "R4", smp_data, expect_word(e));
                    2'b01:   chk(smp_data == expect_word(e), "R5", smp_data, expect_word(e));
                    2'b10:   chk(smp_data == expect_word(e), "R6", smp_data, expect_word(e));
                    default: chk(smp_data == expect_word(e), "R7", smp_data, expect_word(e));
                endcase
                delivered++;
            end
            prev_vh = smp_valid && !smp_ready;
            prev_data = smp_data;
        end
        prev_cs = cs_n; prev_rd = rd_n; prev_hb = hbs; prev_err = tmo_err;
    end

    task automatic run_seg(input bit nw, input bit bp, input int nsamp, input bit do_tmo,
                           input bit do_stall, input string tag);
        int t;
        @(posedge clk); #2;
        rst_n = 1'b0; cfg_nowait = nw; cfg_byte = bp; ignore = 0; stall = 0;
        repeat (3) @(posedge clk);
        #5;
        chk(cs_n && rd_n && !hbs && !smp_valid && !tmo_err, "R1",
            {cs_n, rd_n, hbs, smp_valid, tmo_err}, 5'b11000);
        @(posedge clk); #2;
        rst_n = 1'b1;
        t = 0;
        while (delivered < nsamp / 2 && t < 20000) begin @(posedge clk); t++; end
        if (do_stall) begin
            #2 stall = 1;
            repeat (80) @(posedge clk);
            #2 stall = 0;
        end
        while (delivered < nsamp && t < 20000) begin @(posedge clk); t++; end
        chk(delivered >= nsamp, tag, delivered, nsamp);
        if (do_tmo) begin
            #2 ignore = 1;
            t = 0;
            while (err_cnt == 0 && t < 500) begin @(posedge clk); t++; end
            #2 ignore = 0;
            chk(err_cnt == 1, "R11", err_cnt, 1);
            t = 0;
            while (delivered < nsamp + 4 && t < 5000) begin @(posedge clk); t++; end
            chk(delivered >= nsamp + 4, "R11", delivered, nsamp + 4);
            chk(err_cnt == 1, "R11", err_cnt, 1);
        end else begin
            chk(err_cnt == 0, "R11", err_cnt, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1273));
        run_seg(1'b0, 1'b0, 10, 1'b1, 1'b0, "R4");
        run_seg(1'b0, 1'b1, 10, 1'b0, 1'b1, "R5");
        run_seg(1'b1, 1'b0, 10, 1'b0, 1'b1, "R6");
        run_seg(1'b1, 1'b1, 10, 1'b0, 1'b0, "R7");
        run_seg(1'b0, 1'b1, 6, 1'b1, 1'b0, "R5");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule